// File: doc/BRIEF.md
# Glitch-Filtered Edge Request Detector

This block watches sixteen asynchronous request wires and turns qualified level changes on them into sticky per-line flags. Each wire is first brought into the system clock domain by a two-stage synchroniser. A per-line counter then measures how long the synchronised value has disagreed with the line's accepted (filtered) level. Only when that disagreement has lasted long enough does the filtered level flip. The required length is set by a shared four-bit filter length.

Each accepted transition is classified as rising or falling. It raises the line's flag only if that direction is enabled for the line in the matching mask. Software programs the two masks and the filter length through a small word-wide register port. It reads and clears the flags through the same port by writing ones. A single interrupt output is high while any flag is set.

Top module: `edge_irq_filter`

## Requirements
- R1: After reset, every flag, both masks and the filter length read as 0, and `irq` is low.
- R2: With filter length L, a change held on a line is accepted, and its flag (when enabled) is readable after exactly L+3 rising clock edges counted from the change. After L+2 edges it is not yet set.
- R3: A level that returns before being held for L+1 synchronised cycles is rejected. A single cycle back at the filtered level restarts the count.
- R4: An accepted 0-to-1 change sets the line's flag only if the line's bit in the rising mask (address 0) is 1.
- R5: An accepted 1-to-0 change sets the line's flag only if the line's bit in the falling mask (address 1) is 1.
- R6: With both mask bits set for a line, accepted changes in either direction set its flag.
- R7: An accepted change whose direction is disabled still updates the filtered level. No flag appears later when that direction is enabled afterwards.
- R8: Writing to the flag register (address 3) clears each flag whose data bit is 1 and leaves flags with a 0 data bit unchanged.
- R9: When an accepted enabled edge and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: `irq` is 1 exactly when at least one flag is set.
- R11: Address 2 holds the filter length in data bits 3:0, and its upper read bits are 0. Addresses 0 and 1 read back all 16 written bits. Line n maps to data bit n in all registers.
- R12: A filter length of 0 accepts a change on the first synchronised cycle in which it differs (flag readable after 3 edges).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 16 | Asynchronous request wires, line n on bit n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 rising mask, 1 falling mask, 2 filter length, 3 flags |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register (combinational) |
| irq | output | 1 | High while any flag is set |

## Verification
The two events that can coincide are an enabled edge being accepted on a line and a write-one-to-clear hitting that same flag. The bench times a clear-all write so that its strobe is sampled on exactly the L+3rd edge after the input change, the edge on which the filter accepts. It then reads the flag register and expects the line's bit still set. It then clears the flag alone to show that the same write does clear a flag when no edge competes.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  localparam int unsigned LINES  = 16;
  localparam int unsigned FLEN_W = 4;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [1:0] {
    REG_RISE_EN  = 2'd0,
    REG_FALL_EN  = 2'd1,
    REG_FILT_LEN = 2'd2,
    REG_FLAGS    = 2'd3
  } reg_addr_e;

  // The held-different count has reached the programmed length.
  // ">=" keeps a count left above a shortened length from running on.
  function automatic logic qualified(input logic [FLEN_W-1:0] cnt,
                                     input logic [FLEN_W-1:0] flen);
    return cnt >= flen;
  endfunction

  // Flag update: a set in the same cycle wins over a clear.
  function automatic logic [LINES-1:0] next_flags(input logic [LINES-1:0] cur,
                                                  input logic [LINES-1:0] set_v,
                                                  input logic [LINES-1:0] clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          chain_q[s] <= '0;
        end else if (s == 0) begin
          chain_q[s] <= d_i;
        end else begin
          chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/eirq_line_filter.sv
module eirq_line_filter
  import eirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [FLEN_W-1:0] flen_i,
  output logic              filt_o,
  output logic              rise_o,
  output logic              fall_o
);

  logic [FLEN_W-1:0] cnt_q;
  logic              filt_q;
  logic              differ;
  logic              accept;

  assign differ = sync_i ^ filt_q;
  assign accept = differ && qualified(cnt_q, flen_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (!differ) begin
      cnt_q  <= '0;
    end else if (accept) begin
      filt_q <= sync_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;
  assign rise_o = accept & sync_i;
  assign fall_o = accept & ~sync_i;

  // Filtered level only moves to a value the synchroniser was presenting.
  AST_FILT_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(sync_i) == filt_q)); // R2
  // Agreement with the filtered level wipes the count.
  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i == filt_q) |=> (cnt_q == '0)); // R3
  // An accepted change always flips the filtered level on the next edge.
  AST_ACCEPT_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o || fall_o) |=> (filt_q != $past(filt_q))); // R7

endmodule

// File: rtl/eirq_flag_bank.sv
module eirq_flag_bank
  import eirq_pkg::*;
#(
  parameter int unsigned N = LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);

  logic [N-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= next_flags(flags_q, set_i, clr_i);
  end

  assign flags_o = flags_q;
  assign irq_o   = |flags_q;

  // A flag only rises where an enabled accepted edge was presented.
  AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~$past(flags_q) & ~$past(set_i)) == '0)); // R4
  // A flag only falls where a one was written to it.
  AST_CLEAR_ONLY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags_q) & ~flags_q & ~$past(clr_i)) == '0)); // R8
  // A set beats a concurrent clear.
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R9

endmodule

// File: rtl/edge_irq_filter.sv
module edge_irq_filter
  import eirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  req_in,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic [LINES-1:0]  rise_en_q;
  logic [LINES-1:0]  fall_en_q;
  logic [FLEN_W-1:0] flen_q;
  logic [LINES-1:0]  req_sync;
  logic [LINES-1:0]  filt_lvl;
  logic [LINES-1:0]  rise_evt;
  logic [LINES-1:0]  fall_evt;
  logic [LINES-1:0]  set_vec;
  logic [LINES-1:0]  clr_vec;
  logic [LINES-1:0]  flags;
  reg_addr_e         sel;

  assign sel = reg_addr_e'(addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      flen_q    <= '0;
    end else if (wr_en) begin
      case (sel)
        REG_RISE_EN:  rise_en_q <= wdata[LINES-1:0];
        REG_FALL_EN:  fall_en_q <= wdata[LINES-1:0];
        REG_FILT_LEN: flen_q    <= wdata[FLEN_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_vec = (wr_en && sel == REG_FLAGS) ? wdata[LINES-1:0] : '0;

  eirq_sync #(.W(LINES), .STAGES(2)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (req_in),
    .q_o   (req_sync)
  );

  generate
    for (genvar n = 0; n < LINES; n++) begin : g_line
      eirq_line_filter i_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (req_sync[n]),
        .flen_i (flen_q),
        .filt_o (filt_lvl[n]),
        .rise_o (rise_evt[n]),
        .fall_o (fall_evt[n])
      );
    end
  endgenerate

  assign set_vec = (rise_evt & rise_en_q) | (fall_evt & fall_en_q);

  eirq_flag_bank #(.N(LINES)) i_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flags),
    .irq_o   (irq)
  );

  always_comb begin
    rdata = '0;
    case (sel)
      REG_RISE_EN:  rdata[LINES-1:0]  = rise_en_q;
      REG_FALL_EN:  rdata[LINES-1:0]  = fall_en_q;
      REG_FILT_LEN: rdata[FLEN_W-1:0] = flen_q;
      REG_FLAGS:    rdata[LINES-1:0]  = flags;
      default: ;
    endcase
  end

  // Filtered levels leave reset at zero and only flip on an accepted event.
  AST_LEVEL_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_lvl ^ $past(filt_lvl)) & ~$past(rise_evt | fall_evt)) == '0); // R3
  // The interrupt follows the flag register seen through the port.
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == REG_FLAGS) |-> (irq == (rdata != '0))); // R10

endmodule

// File: tb/test_edge_irq_filter.sv
`timescale 1ns/1ps
module test_edge_irq_filter;
  import eirq_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [LINES-1:0]  req_in = '0;
  logic              wr_en = 1'b0;
  logic [1:0]        addr = 2'd0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  edge_irq_filter i_edge_irq_filter (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic [3:0] line;
    logic [3:0] flen;
    logic       start;
    logic       rise;
    logic       fall;
    logic [4:0] wcyc;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  // Edge counts: flag readable iff wcyc >= flen+3 and direction enabled.
  localparam vec_t VECS [12] = '{
    '{4'd0,  4'd0,  1'b0, 1'b1, 1'b0, 5'd3,  1'b1, 4'd12}, // R12
    '{4'd0,  4'd0,  1'b0, 1'b1, 1'b0, 5'd2,  1'b0, 4'd12}, // R12
    '{4'd5,  4'd4,  1'b0, 1'b1, 1'b0, 5'd7,  1'b1, 4'd2},  // R2
    '{4'd5,  4'd4,  1'b0, 1'b1, 1'b0, 5'd6,  1'b0, 4'd2},  // R2
    '{4'd9,  4'd2,  1'b1, 1'b0, 1'b1, 5'd5,  1'b1, 4'd5},  // R5
    '{4'd9,  4'd2,  1'b1, 1'b1, 1'b0, 5'd8,  1'b0, 4'd5},  // R5
    '{4'd15, 4'd15, 1'b0, 1'b1, 1'b0, 5'd18, 1'b1, 4'd2},  // R2
    '{4'd15, 4'd15, 1'b0, 1'b1, 1'b0, 5'd17, 1'b0, 4'd2},  // R2
    '{4'd3,  4'd1,  1'b0, 1'b1, 1'b1, 5'd6,  1'b1, 4'd6},  // R6
    '{4'd3,  4'd1,  1'b1, 1'b1, 1'b1, 5'd6,  1'b1, 4'd6},  // R6
    '{4'd7,  4'd3,  1'b0, 1'b0, 1'b1, 5'd9,  1'b0, 4'd4},  // R4
    '{4'd10, 4'd0,  1'b0, 1'b1, 1'b0, 5'd4,  1'b1, 4'd4}   // R4
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle(input logic [15:0] lvl);
    wr(2'd2, 16'h0); wr(2'd0, 16'h0); wr(2'd1, 16'h0);
    req_in = lvl;
    repeat (6) @(negedge clk);
    wr(2'd3, 16'hFFFF);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d;
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reset register", 32'(d), 32'h0);
    end
    check("R1 reset irq", 32'(irq), 32'h0);

    // R11 register readback
    wr(2'd0, 16'hA5A5); wr(2'd1, 16'h5A5A); wr(2'd2, 16'hFFFF);
    rd(2'd0, d); check("R11 rising mask", 32'(d), 32'hA5A5);
    rd(2'd1, d); check("R11 falling mask", 32'(d), 32'h5A5A);
    rd(2'd2, d); check("R11 filter length", 32'(d), 32'h000F);

    // table walk
    for (int i = 0; i < 12; i++) begin
      settle(VECS[i].start ? (16'h1 << VECS[i].line) : 16'h0);
      wr(2'd2, 16'(VECS[i].flen));
      wr(2'd0, VECS[i].rise ? (16'h1 << VECS[i].line) : 16'h0);
      wr(2'd1, VECS[i].fall ? (16'h1 << VECS[i].line) : 16'h0);
      req_in[VECS[i].line] = ~VECS[i].start;
      repeat (VECS[i].wcyc) @(posedge clk);
      @(negedge clk);
      e = VECS[i].exp ? (16'h1 << VECS[i].line) : 16'h0;
      rd(2'd3, d);
      check($sformatf("R%0d vector %0d flags", VECS[i].req, i), 32'(d), 32'(e));
      check($sformatf("R10 vector %0d irq", i), 32'(irq), 32'(e != 0));
    end

    // R3 glitch rejection, filter length 4
    settle(16'h0);
    wr(2'd2, 16'd4); wr(2'd0, 16'hFFFF);
    req_in[2] = 1'b1; repeat (4) @(negedge clk); req_in[2] = 1'b0;
    repeat (12) @(negedge clk);
    rd(2'd3, d); check("R3 short pulse rejected", 32'(d), 32'h0);
    req_in[2] = 1'b1; repeat (4) @(negedge clk); req_in[2] = 1'b0;
    @(negedge clk);
    req_in[2] = 1'b1; repeat (4) @(negedge clk); req_in[2] = 1'b0;
    repeat (12) @(negedge clk);
    rd(2'd3, d); check("R3 split pulse restarts count", 32'(d), 32'h0);
    req_in[2] = 1'b1; repeat (5) @(negedge clk); req_in[2] = 1'b0;
    repeat (12) @(negedge clk);
    rd(2'd3, d); check("R3 pulse of L+1 accepted", 32'(d), 32'h0004);

    // R8 write-one-to-clear
    settle(16'h0);
    wr(2'd0, 16'hFFFF);
    req_in[1] = 1'b1; req_in[2] = 1'b1;
    repeat (6) @(negedge clk);
    rd(2'd3, d); check("R8 two flags set", 32'(d), 32'h0006);
    wr(2'd3, 16'h0002);
    rd(2'd3, d); check("R8 clear selected bit", 32'(d), 32'h0004);
    wr(2'd3, 16'h0000);
    rd(2'd3, d); check("R8 zero write keeps flag", 32'(d), 32'h0004);
    check("R10 irq with one flag", 32'(irq), 32'h1);

    // R9 set wins over simultaneous clear, filter length 2
    settle(16'h0);
    wr(2'd2, 16'd2); wr(2'd0, 16'h0010);
    req_in[4] = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd3; wdata = 16'hFFFF;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd3, d); check("R9 set beats clear", 32'(d), 32'h0010);
    wr(2'd3, 16'h0010);
    rd(2'd3, d); check("R9 later clear works", 32'(d), 32'h0);
    check("R10 irq low with no flags", 32'(irq), 32'h0);

    // R7 disabled edge still moves the filtered level
    settle(16'h0);
    req_in[6] = 1'b1;
    repeat (8) @(negedge clk);
    rd(2'd3, d); check("R7 disabled rise no flag", 32'(d), 32'h0);
    wr(2'd0, 16'h0040);
    repeat (10) @(negedge clk);
    rd(2'd3, d); check("R7 no late rise flag", 32'(d), 32'h0);
    wr(2'd1, 16'h0040);
    req_in[6] = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd3, d); check("R7 fall seen after level moved", 32'(d), 32'h0040);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule